// File: doc/BRIEF.md
# Module-Redundant Parallel FIR Bank

This block runs four FIR filters that share one impulse response but each filter has its own input stream. Three further filters with the same coefficients guard them. Each guard filter is fed the sum of three of the data inputs. Because convolution is linear, a guard output must match the same three-way sum of the data filter outputs, sample by sample. Comparing each guard against that recomputed sum gives a three-bit syndrome. The syndrome works like a Hamming code in which every bit position is a whole filter. It locates a single faulty filter among the seven. When the faulty filter is a data filter, its output is rebuilt from a guard output and two healthy data outputs.

The user presents four signed samples together with a valid strobe. Two cycles later the four corrected results appear, along with the syndrome and an error flag. A fault-injection port can XOR a mask onto the output of any one of the seven filters, so that single faults can be forced on purpose.

Top module: `ecc_fir_bank`

## Requirements
- R1: With no fault injected, each output lane equals sum over k of h[k]*x[n-k] for its own input stream, with taps h = {2, 7, -5, 3} (k = 0..3) by default. The history is zero after reset and advances only on valid samples. Results are AW-bit two's complement.
- R2: A sample accepted with vld_i high at one rising edge appears on y_o with vld_o high after the second following edge. vld_o is low after the first edge. All outputs are zero and vld_o is low after reset.
- R3: Syndrome bit 2 flags a mismatch between guard 1 and lanes 0+1+2. Bit 1 flags a mismatch between guard 2 and lanes 0+1+3. Bit 0 flags a mismatch between guard 3 and lanes 0+2+3. The syndrome is 000 when there is no fault.
- R4: Syndrome 111 marks lane 0 as faulty. Its output is rebuilt as guard1 - lane1 - lane2, which gives the fault-free value.
- R5: Syndromes 110, 101 and 011 mark lanes 1, 2 and 3. These lanes are rebuilt as guard1 - lane0 - lane2, guard1 - lane0 - lane1 and guard2 - lane0 - lane1 respectively, each giving the fault-free value.
- R6: A syndrome with exactly one bit set is a guard-filter fault. All four lanes then pass through unchanged.
- R7: err_o is high exactly when syn_o is nonzero.
- R8: fault_sel_i values 0..3 pick data lanes 0..3, values 4..6 pick guards 1..3, and value 7 picks nothing. The mask is XORed onto the chosen filter's output only while fault_en_i is high. With fault_en_i low, the mask has no effect.
- R9: Guard inputs are widened by 2 bits and accumulators are sized so that full-scale inputs (all -128 or all +127) never raise a false syndrome.
- R10: While vld_i is low, the outputs hold their values and no filter history advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input sample strobe |
| x_i | input | 4*DW | Four signed samples, lane i at bits [i*DW +: DW] |
| fault_en_i | input | 1 | Enables fault injection |
| fault_sel_i | input | 3 | Target filter: 0-3 data lanes, 4-6 guards, 7 none |
| fault_mask_i | input | AW | XOR mask applied to the chosen filter output |
| y_o | output | 4*AW | Corrected results, lane i at bits [i*AW +: AW] |
| vld_o | output | 1 | Output strobe, two cycles after vld_i |
| syn_o | output | 3 | Syndrome {guard1, guard2, guard3 mismatch} |
| err_o | output | 1 | Any guard mismatch |

## Verification
A corrupted tap delay line or accumulator in one data lane is caught at the ports. It shows as a nonzero syndrome on the very next output sample, while that lane's output still stays correct. A wrong entry in the syndrome decode, or a wrong reconstruction equation, shows as a wrong value on the selected lane for that same sample. A stale history register shows up only on later samples, because a filter's output depends on its last four inputs. For that reason the sweeps send several samples in a row through each lane and each fault target.

// File: rtl/ecc_fir_pkg.sv
package ecc_fir_pkg;

  localparam int NDATA = 4;
  localparam int NCHK  = 3;

  // syndrome bit order: {guard1, guard2, guard3}
  typedef enum logic [2:0] {
    SYN_NONE = 3'b000,
    SYN_G3   = 3'b001,
    SYN_G2   = 3'b010,
    SYN_D3   = 3'b011,
    SYN_G1   = 3'b100,
    SYN_D2   = 3'b101,
    SYN_D1   = 3'b110,
    SYN_D0   = 3'b111
  } syn_e;

  // lanes summed into each guard, bit i = data lane i
  localparam logic [NDATA-1:0] GUARD_MEMB [NCHK] = '{4'b0111, 4'b1011, 4'b1101};

  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + 2 + $clog2(taps);
  endfunction

endpackage

// File: rtl/ecc_fir_tap.sv
module ecc_fir_tap #(
  parameter int IW   = 8,
  parameter int CW   = 8,
  parameter int TAPS = 4,
  parameter int AW   = 20,
  parameter logic [TAPS*CW-1:0] COEFS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [IW-1:0] x_i,
  output logic [AW-1:0] y_o,
  output logic          vld_o
);

  localparam int DL = TAPS - 1;

  logic signed [IW-1:0] dly_q [DL];
  logic signed [IW-1:0] win   [TAPS];
  logic signed [AW-1:0] acc;
  logic        [AW-1:0] y_q;
  logic                 vld_q;

  always_comb begin
    win[0] = $signed(x_i);
    for (int k = 1; k < TAPS; k++) win[k] = dly_q[k-1];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + AW'(win[k]) * AW'($signed(COEFS[k*CW +: CW]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DL; k++) dly_q[k] <= '0;
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        y_q      <= acc;
        dly_q[0] <= $signed(x_i);
        for (int k = 1; k < DL; k++) dly_q[k] <= dly_q[k-1];
      end
    end
  end

  assign y_o   = y_q;
  assign vld_o = vld_q;

  assert_fir_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vld_i) |-> ($stable(y_q) && $stable(dly_q[0])));

  initial assert_taps_min_R1: assert (TAPS >= 2);

endmodule

// File: rtl/ecc_fir_decode.sv
module ecc_fir_decode
  import ecc_fir_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        vld_i,
  input  logic [NDATA-1:0][AW-1:0]    y_i,
  input  logic [NCHK-1:0][AW-1:0]     g_i,
  output logic [NDATA-1:0][AW-1:0]    y_o,
  output logic [2:0]                  syn_o,
  output logic                        err_o,
  output logic                        vld_o
);

  logic [NCHK-1:0][AW-1:0]  ref_sum;
  logic [2:0]               syn_c;
  logic [NDATA-1:0][AW-1:0] fix_c;

  logic [NDATA-1:0][AW-1:0] y_q;
  logic [2:0]               syn_q;
  logic                     err_q;
  logic                     vld_q;

  always_comb begin
    for (int j = 0; j < NCHK; j++) begin
      ref_sum[j] = '0;
      for (int i = 0; i < NDATA; i++)
        if (GUARD_MEMB[j][i]) ref_sum[j] = ref_sum[j] + y_i[i];
    end
    syn_c = {g_i[0] != ref_sum[0], g_i[1] != ref_sum[1], g_i[2] != ref_sum[2]};
  end

  always_comb begin
    fix_c = y_i;
    case (syn_e'(syn_c))
      SYN_D0:  fix_c[0] = g_i[0] - y_i[1] - y_i[2];
      SYN_D1:  fix_c[1] = g_i[0] - y_i[0] - y_i[2];
      SYN_D2:  fix_c[2] = g_i[0] - y_i[0] - y_i[1];
      SYN_D3:  fix_c[3] = g_i[1] - y_i[0] - y_i[1];
      default: ;  // clean or guard fault: pass through
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q   <= '0;
      syn_q <= '0;
      err_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        y_q   <= fix_c;
        syn_q <= syn_c;
        err_q <= |syn_c;
      end
    end
  end

  assign y_o   = y_q;
  assign syn_o = syn_q;
  assign err_o = err_q;
  assign vld_o = vld_q;

  assert_vld_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q == $past(vld_i));

  assert_clean_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vld_i && syn_c == 3'b000) |-> (y_q == $past(y_i) && syn_q == 3'b000));

  assert_guard_fault_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vld_i && $countones(syn_c) == 1) |-> (y_q == $past(y_i) && err_q));

  assert_err_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q == (syn_q != 3'b000));

  assert_out_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vld_i) |-> ($stable(y_q) && $stable(syn_q)));

endmodule

// File: rtl/ecc_fir_bank.sv
module ecc_fir_bank
  import ecc_fir_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] COEFS = 32'h03FB_0702,
  localparam int AW  = ecc_fir_pkg::acc_width(DW, CW, TAPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [4*DW-1:0]    x_i,
  input  logic               fault_en_i,
  input  logic [2:0]         fault_sel_i,
  input  logic [AW-1:0]      fault_mask_i,
  output logic [4*AW-1:0]    y_o,
  output logic               vld_o,
  output logic [2:0]         syn_o,
  output logic               err_o
);

  localparam int GW = DW + 2;
  localparam int NF = NDATA + NCHK;

  logic [NDATA-1:0][AW-1:0] y_raw, y_flt;
  logic [NCHK-1:0][AW-1:0]  g_raw, g_flt;
  logic [NCHK-1:0][GW-1:0]  g_in;
  logic [NF-1:0]            fvld;
  logic                     fvld_all;
  logic [NDATA-1:0][AW-1:0] y_fix;

  // guard inputs: widened sums of their member lanes
  always_comb begin
    for (int j = 0; j < NCHK; j++) begin
      g_in[j] = '0;
      for (int i = 0; i < NDATA; i++)
        if (GUARD_MEMB[j][i]) g_in[j] = g_in[j] + GW'($signed(x_i[i*DW +: DW]));
    end
  end

  for (genvar i = 0; i < NDATA; i++) begin : g_data
    ecc_fir_tap #(.IW(DW), .CW(CW), .TAPS(TAPS), .AW(AW), .COEFS(COEFS)) u_tap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld_i),
      .x_i   (x_i[i*DW +: DW]),
      .y_o   (y_raw[i]),
      .vld_o (fvld[i])
    );
    assign y_flt[i] = y_raw[i] ^
      ((fault_en_i && fault_sel_i == 3'(i)) ? fault_mask_i : '0);
  end

  for (genvar j = 0; j < NCHK; j++) begin : g_guard
    ecc_fir_tap #(.IW(GW), .CW(CW), .TAPS(TAPS), .AW(AW), .COEFS(COEFS)) u_tap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld_i),
      .x_i   (g_in[j]),
      .y_o   (g_raw[j]),
      .vld_o (fvld[NDATA+j])
    );
    assign g_flt[j] = g_raw[j] ^
      ((fault_en_i && fault_sel_i == 3'(NDATA + j)) ? fault_mask_i : '0);
  end

  assign fvld_all = &fvld;

  ecc_fir_decode #(.AW(AW)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (fvld_all),
    .y_i   (y_flt),
    .g_i   (g_flt),
    .y_o   (y_fix),
    .syn_o (syn_o),
    .err_o (err_o),
    .vld_o (vld_o)
  );

  assign y_o = y_fix;

  assert_no_false_syn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fvld_all && !fault_en_i) |-> syn_o == 3'b000);

  assert_fault_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fvld_all && !fault_en_i) |-> y_o == $past(y_raw));

endmodule

// File: tb/ecc_fir_bank_tb.sv
`timescale 1ns/1ps
module ecc_fir_bank_tb_top;

  localparam int DW = 8, CW = 8, TAPS = 4, AW = 20;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            vld_i = 1'b0;
  logic [4*DW-1:0] x_i = '0;
  logic            fault_en_i = 1'b0;
  logic [2:0]      fault_sel_i = 3'd7;
  logic [AW-1:0]   fault_mask_i = '0;
  logic [4*AW-1:0] y_o;
  logic            vld_o;
  logic [2:0]      syn_o;
  logic            err_o;

  int n_chk = 0, n_fail = 0;
  int hist [4][TAPS];
  int coef [TAPS] = '{2, 7, -5, 3};
  bit done = 0;

  always #10 clk_i = ~clk_i;

  ecc_fir_bank #(.DW(DW), .CW(CW), .TAPS(TAPS), .COEFS(32'h03FB_0702)) dut_i (
    .clk_i, .rst_ni, .vld_i, .x_i, .fault_en_i, .fault_sel_i, .fault_mask_i,
    .y_o, .vld_o, .syn_o, .err_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_syn(input bit fen, input int sel, input logic [AW-1:0] m);
    if (!fen || m == '0) return 3'b000;
    case (sel)
      0: return 3'b111;
      1: return 3'b110;
      2: return 3'b101;
      3: return 3'b011;
      4: return 3'b100;
      5: return 3'b010;
      6: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic send(input int xs [4], input bit fen, input int sel, input logic [AW-1:0] m,
                      input string xtag);
    int ye [4];
    logic [2:0] es;
    string tag;
    for (int i = 0; i < 4; i++) begin
      for (int k = TAPS-1; k > 0; k--) hist[i][k] = hist[i][k-1];
      hist[i][0] = xs[i];
      ye[i] = 0;
      for (int k = 0; k < TAPS; k++) ye[i] += coef[k] * hist[i][k];
    end
    es = exp_syn(fen, sel, m);
    case (es)
      3'b111: tag = "R4";
      3'b110, 3'b101, 3'b011: tag = "R5";
      3'b100, 3'b010, 3'b001: tag = "R6";
      default: tag = "R1";
    endcase
    @(negedge clk_i);
    vld_i = 1'b1;
    for (int i = 0; i < 4; i++) x_i[i*DW +: DW] = xs[i][DW-1:0];
    fault_en_i = fen; fault_sel_i = 3'(sel); fault_mask_i = m;
    @(posedge clk_i);
    @(negedge clk_i);
    vld_i = 1'b0;
    chk("R2 vld low after one edge", {31'b0, vld_o}, 32'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 vld high after two edges", {31'b0, vld_o}, 32'd1);
    for (int i = 0; i < 4; i++)
      chk({tag, " ", xtag, " lane"}, {12'b0, y_o[i*AW +: AW]}, {12'b0, ye[i][AW-1:0]});
    chk({"R3 syn ", xtag}, {29'b0, syn_o}, {29'b0, es});
    chk("R7 err", {31'b0, err_o}, {31'b0, es != 3'b000});
    fault_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int xs [4];
    logic [AW-1:0] masks [4] = '{20'h00001, 20'h80000, 20'h0ABCD, 20'hFFFFF};
    logic [4*AW-1:0] snap;
    for (int i = 0; i < 4; i++) for (int k = 0; k < TAPS; k++) hist[i][k] = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset y", {31'b0, y_o == '0}, 32'd1);
    chk("R2 reset vld", {31'b0, vld_o}, 32'd0);
    chk("R3 reset syn", {29'b0, syn_o}, 32'd0);
    chk("R7 reset err", {31'b0, err_o}, 32'd0);

    // sweep every fault target and mask, several samples each
    for (int sel = 0; sel < 8; sel++)
      for (int mi = 0; mi < 4; mi++)
        for (int r = 0; r < 3; r++) begin
          for (int i = 0; i < 4; i++) xs[i] = int'($urandom_range(255)) - 128;
          send(xs, 1'b1, sel, masks[mi], "sweep");
        end

    // R8: mask present but injection disabled
    for (int sel = 0; sel < 7; sel++) begin
      for (int i = 0; i < 4; i++) xs[i] = int'($urandom_range(255)) - 128;
      send(xs, 1'b0, sel, 20'hFFFFF, "R8 fault disabled");
    end

    // R9: full-scale inputs
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 4; i++) xs[i] = -128;
      send(xs, 1'b0, 7, '0, "R9 neg full");
    end
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 4; i++) xs[i] = 127;
      send(xs, 1'b0, 7, '0, "R9 pos full");
    end
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 4; i++) xs[i] = ((r + i) % 2) ? 127 : -128;
      send(xs, 1'b1, r % 4, 20'h7FFFF, "R9 alt full");
    end

    // R10: idle cycles with noisy inputs leave outputs and history alone
    snap = y_o;
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) x_i[i*DW +: DW] = 8'h5A;
    fault_en_i = 1'b1; fault_sel_i = 3'd0; fault_mask_i = 20'hFFFFF;
    repeat (4) @(negedge clk_i);
    chk("R10 outputs held", {31'b0, y_o == snap}, 32'd1);
    chk("R10 vld low while idle", {31'b0, vld_o}, 32'd0);
    fault_en_i = 1'b0;
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 4; i++) xs[i] = 10 * (i + 1) - 3 * r;
      send(xs, 1'b0, 7, '0, "R10 history intact");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule